// File: doc/BRIEF.md
# Indexed Register Window with Minimum-Luma Statistic

This block gives a host a small window into a larger bank of 16-bit control and status registers. The host sees four word slots. It writes an index into the first slot. It then reads or writes the register that index names through the second slot. The other two slots are reserved. Each register in the bank carries an access class: read-write, write-only or read-only. Any other index is unmapped. The block enforces the class on every data access.

One read-only register reports a live statistic: the smallest luma code seen during the last complete video field. A tracker follows the luma sample stream. At each field boundary it publishes its running minimum and restarts from the largest code. The host can read the result at any point during the following field.

Host access is run by a two-state machine. `ST_IDLE` moves to `ST_RESP` on a read request. `ST_RESP` stays in `ST_RESP` if another read arrives in that cycle, and returns to `ST_IDLE` otherwise. Writes complete at the clock edge that accepts them and do not change state.

Top module: `ireg_port`

## Requirements
- R1: After synchronous reset the index is 0x0000, `host_rdata` is 0 and `host_rvalid` is low. The read-write registers at indices 0x0001, 0x0002 and 0x0003 hold 0x0010, 0x0000 and 0x02CF. The write-only register is 0x0000. The minimum-luma register reads 0x00FF.
- R2: A write to word slot 0 (`host_addr`=0) loads the index from `host_wdata`. A read of slot 0 returns the current index.
- R3: The index changes only on a write to slot 0. Accesses to slot 1 (`host_addr`=1) never advance it, so repeated data accesses all reach the same register.
- R4: With a read-write index (0x0001 to 0x0003) selected, a write to slot 1 stores `host_wdata`. A later read of slot 1 returns it. The stored values also appear on `cfg_rw_o`, with index 0x0001 in bits 15:0.
- R5: Index 0x0006 is write-only. A slot 1 write updates `ratio_o`. A slot 1 read returns 0.
- R6: For an unmapped index, a slot 1 read returns 0. A slot 1 write changes no register, which `cfg_rw_o` and `ratio_o` show.
- R7: Index 0x00AD is read-only. A slot 1 write to it is ignored and the value read back is unchanged.
- R8: When `field_start` is high, the minimum of all samples with `luma_valid` high since the previous `field_start` is published at index 0x00AD, zero-extended. If there were no such samples, 0xFF is published. Samples with `luma_valid` low are ignored. A valid sample that arrives together with `field_start` belongs to the new field.
- R9: Slots 2 and 3 are reserved. Reads return 0 and writes change nothing, including the index.
- R10: `host_rvalid` is high in exactly the cycle after each read request (`host_req` high, `host_wr` low), with `host_rdata` valid in that cycle. It is low in all other cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| host_req | input | 1 | Host access request, one cycle per access |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | 2 | Word slot: 0 index, 1 data, 2 and 3 reserved |
| host_wdata | input | 16 | Write data |
| host_rdata | output | 16 | Read data, registered |
| host_rvalid | output | 1 | Read data valid |
| field_start | input | 1 | Pulse at the first cycle of a field |
| luma_valid | input | 1 | Luma sample qualifier |
| luma_data | input | 8 | Luma sample code |
| cfg_rw_o | output | 48 | Read-write registers, index 0x0001 in bits 15:0 |
| ratio_o | output | 16 | Write-only ratio control register |

## Verification
Read data is registered once, so every read result is due in the cycle that follows the request edge. A write takes effect at its own edge, so a read issued in the next cycle already sees it. The scoreboard records how many requests went into each edge. It then compares `host_rvalid` and `host_rdata` a quarter period after that edge, and counts any response in an idle cycle as a failure. The published minimum changes at the `field_start` edge, so its read is issued only after that edge.

// File: rtl/ireg_pkg.sv
package ireg_pkg;
    localparam int IDX_W = 16;
    localparam logic [IDX_W-1:0] IDX_RATIO   = 16'h0006;
    localparam logic [IDX_W-1:0] IDX_MINLUMA = 16'h00AD;

    typedef enum logic [1:0] {ACC_NONE, ACC_RO, ACC_WO, ACC_RW} acc_e;

    typedef enum logic {ST_IDLE, ST_RESP} host_st_e;

    // Read-write registers occupy indices 1..nrw
    function automatic acc_e classify(logic [IDX_W-1:0] idx, int nrw);
        if (idx == IDX_RATIO)                           return ACC_WO;
        if (idx == IDX_MINLUMA)                         return ACC_RO;
        if (32'(idx) >= 1 && 32'(idx) <= nrw)           return ACC_RW;
        return ACC_NONE;
    endfunction

    function automatic logic [15:0] rw_reset(int slot);
        case (slot)
            0:       return 16'h0010;
            1:       return 16'h0000;
            default: return 16'h02CF;
        endcase
    endfunction
endpackage

// File: rtl/ireg_luma_min.sv
module ireg_luma_min #(
    parameter int LUMA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              field_start,
    input  logic              luma_valid,
    input  logic [LUMA_W-1:0] luma_data,
    output logic [LUMA_W-1:0] min_pub
);
    localparam logic [LUMA_W-1:0] MAX_CODE = '1;

    logic [LUMA_W-1:0] run_min;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_min <= MAX_CODE;
            min_pub <= MAX_CODE;
        end else if (field_start) begin
            min_pub <= run_min;
            run_min <= luma_valid ? luma_data : MAX_CODE;
        end else if (luma_valid && luma_data < run_min) begin
            run_min <= luma_data;
        end
    end

    assert_pub_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !field_start |=> $stable(min_pub));
    assert_restart_R8: assert property (@(posedge clk) disable iff (rst)
        (field_start && !luma_valid) |=> run_min == MAX_CODE);
endmodule

// File: rtl/ireg_bank.sv
module ireg_bank
    import ireg_pkg::*;
#(
    parameter int NUM_RW = 3,
    parameter int REG_W  = 16,
    parameter int LUMA_W = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_en,
    input  logic [IDX_W-1:0]        idx,
    input  logic [REG_W-1:0]        wr_data,
    input  logic [LUMA_W-1:0]       min_luma,
    output logic [REG_W-1:0]        rd_data,
    output logic [NUM_RW*REG_W-1:0] cfg_rw,
    output logic [REG_W-1:0]        ratio
);
    acc_e attr;
    assign attr = classify(idx, NUM_RW);

    logic [REG_W-1:0] rw_q [NUM_RW];

    for (genvar g = 0; g < NUM_RW; g++) begin : g_rw
        always_ff @(posedge clk) begin
            if (rst)
                rw_q[g] <= REG_W'(rw_reset(g));
            else if (wr_en && attr == ACC_RW && idx == IDX_W'(g + 1))
                rw_q[g] <= wr_data;
        end
        assign cfg_rw[g*REG_W +: REG_W] = rw_q[g];
    end

    always_ff @(posedge clk) begin
        if (rst)
            ratio <= '0;
        else if (wr_en && attr == ACC_WO)
            ratio <= wr_data;
    end

    always_comb begin
        rd_data = '0;
        unique case (attr)
            ACC_RO: rd_data = REG_W'(min_luma);
            ACC_RW: begin
                for (int i = 0; i < NUM_RW; i++)
                    if (idx == IDX_W'(i + 1)) rd_data = rw_q[i];
            end
            default: rd_data = '0;
        endcase
    end

    assert_ratio_guard_R6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && attr != ACC_WO) |=> $stable(ratio));
endmodule

// File: rtl/ireg_host_fsm.sv
module ireg_host_fsm
    import ireg_pkg::*;
#(
    parameter int REG_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req,
    input  logic             wr,
    input  logic [1:0]       addr,
    input  logic [REG_W-1:0] wdata,
    input  logic [REG_W-1:0] bank_rd,
    output logic             bank_wr,
    output logic [IDX_W-1:0] index,
    output logic [REG_W-1:0] rdata,
    output logic             rvalid
);
    host_st_e state, state_nx;
    logic rd_req;

    assign rd_req  = req && !wr;
    assign bank_wr = req && wr && addr == 2'd1;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (rd_req)  state_nx = ST_RESP;
            ST_RESP: if (!rd_req) state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_nx;
    end

    assign rvalid = (state == ST_RESP);

    always_ff @(posedge clk) begin
        if (rst) begin
            index <= '0;
            rdata <= '0;
        end else begin
            if (req && wr && addr == 2'd0)
                index <= IDX_W'(wdata);
            if (rd_req) begin
                unique case (addr)
                    2'd0:    rdata <= REG_W'(index);
                    2'd1:    rdata <= bank_rd;
                    default: rdata <= '0;
                endcase
            end
        end
    end

    assert_rvalid_due_R10: assert property (@(posedge clk) disable iff (rst)
        rd_req |=> rvalid);
    assert_rvalid_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        !rd_req |=> !rvalid);
    assert_reserved_zero_R9: assert property (@(posedge clk) disable iff (rst)
        (rd_req && addr[1]) |=> rdata == '0);
    assert_index_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !(req && wr && addr == 2'd0) |=> $stable(index));
endmodule

// File: rtl/ireg_port.sv
module ireg_port
    import ireg_pkg::*;
#(
    parameter int NUM_RW = 3,
    parameter int REG_W  = 16,
    parameter int LUMA_W = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    host_req,
    input  logic                    host_wr,
    input  logic [1:0]              host_addr,
    input  logic [REG_W-1:0]        host_wdata,
    output logic [REG_W-1:0]        host_rdata,
    output logic                    host_rvalid,
    input  logic                    field_start,
    input  logic                    luma_valid,
    input  logic [LUMA_W-1:0]       luma_data,
    output logic [NUM_RW*REG_W-1:0] cfg_rw_o,
    output logic [REG_W-1:0]        ratio_o
);
    logic [IDX_W-1:0]  index;
    logic              bank_wr;
    logic [REG_W-1:0]  bank_rd;
    logic [LUMA_W-1:0] min_pub;

    ireg_host_fsm #(.REG_W(REG_W)) u_host (
        .clk(clk), .rst(rst), .req(host_req), .wr(host_wr), .addr(host_addr),
        .wdata(host_wdata), .bank_rd(bank_rd), .bank_wr(bank_wr), .index(index),
        .rdata(host_rdata), .rvalid(host_rvalid)
    );

    ireg_bank #(.NUM_RW(NUM_RW), .REG_W(REG_W), .LUMA_W(LUMA_W)) u_bank (
        .clk(clk), .rst(rst), .wr_en(bank_wr), .idx(index), .wr_data(host_wdata),
        .min_luma(min_pub), .rd_data(bank_rd), .cfg_rw(cfg_rw_o), .ratio(ratio_o)
    );

    ireg_luma_min #(.LUMA_W(LUMA_W)) u_luma (
        .clk(clk), .rst(rst), .field_start(field_start), .luma_valid(luma_valid),
        .luma_data(luma_data), .min_pub(min_pub)
    );
endmodule

// File: tb/ireg_port_tb_top.sv
module ireg_port_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 0, rst = 1;
    logic        host_req = 0, host_wr = 0;
    logic [1:0]  host_addr = 0;
    logic [15:0] host_wdata = 0;
    logic [15:0] host_rdata;
    logic        host_rvalid;
    logic        field_start = 0, luma_valid = 0;
    logic [7:0]  luma_data = 0;
    logic [47:0] cfg_rw_o;
    logic [15:0] ratio_o;

    int total = 0, fails = 0, pend;
    logic [15:0] exp_q[$];
    string       tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    ireg_port dut_i (
        .clk(clk), .rst(rst), .host_req(host_req), .host_wr(host_wr),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .host_rvalid(host_rvalid), .field_start(field_start), .luma_valid(luma_valid),
        .luma_data(luma_data), .cfg_rw_o(cfg_rw_o), .ratio_o(ratio_o)
    );

    task automatic chk(logic [63:0] act, logic [63:0] exp, string tag);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: results of requests taken at an edge are compared a quarter period later
    initial forever begin
        @(posedge clk);
        pend = exp_q.size();
        #(CLK_PERIOD/4);
        if (pend > 0) begin
            chk({47'b0, host_rvalid, host_rdata}, {47'b0, 1'b1, exp_q.pop_front()},
                tag_q.pop_front());
        end else if (host_rvalid && !rst) begin
            total++; fails++;
            $display("FAIL R10 actual=rvalid 1 expected=rvalid 0");
        end
    end

    // Driver tasks: called at a negedge, return at the next negedge
    task automatic hwrite(logic [1:0] a, logic [15:0] d);
        host_req = 1; host_wr = 1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_req = 0; host_wr = 0;
    endtask

    task automatic hread(logic [1:0] a, logic [15:0] exp, string tag);
        host_req = 1; host_wr = 0; host_addr = a;
        exp_q.push_back(exp); tag_q.push_back(tag);
        @(negedge clk);
        host_req = 0;
    endtask

    task automatic luma(logic fs, logic v, logic [7:0] d);
        field_start = fs; luma_valid = v; luma_data = d;
        @(negedge clk);
        field_start = 0; luma_valid = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 reset values
        chk(host_rvalid, 0, "R1 rvalid");
        chk(host_rdata, 0, "R1 rdata");
        chk(cfg_rw_o, 48'h02CF_0000_0010, "R1 rw reset");
        chk(ratio_o, 0, "R1 ratio reset");
        hread(2'd0, 16'h0000, "R1 index reset");
        hwrite(2'd0, 16'h00AD);
        hread(2'd1, 16'h00FF, "R1 minluma reset");
        // R2 / R4 / R3
        hwrite(2'd0, 16'h0001);
        hread(2'd0, 16'h0001, "R2 index readback");
        hread(2'd1, 16'h0010, "R1 reg1 reset");
        hwrite(2'd1, 16'h1234);
        hread(2'd1, 16'h1234, "R4 rw readback");
        hread(2'd1, 16'h1234, "R3 repeat access");
        hread(2'd0, 16'h0001, "R3 no auto-increment");
        chk(cfg_rw_o, 48'h02CF_0000_1234, "R4 cfg_rw");
        hwrite(2'd0, 16'h0003);
        hwrite(2'd1, 16'hA5A5);
        hread(2'd1, 16'hA5A5, "R4 reg3 readback");
        chk(cfg_rw_o, 48'hA5A5_0000_1234, "R4 cfg_rw reg3");
        // R5 write-only
        hwrite(2'd0, 16'h0006);
        hwrite(2'd1, 16'hBEEF);
        chk(ratio_o, 16'hBEEF, "R5 ratio_o");
        hread(2'd1, 16'h0000, "R5 write-only reads zero");
        // R6 unmapped
        hwrite(2'd0, 16'h0040);
        hwrite(2'd1, 16'h5555);
        hread(2'd1, 16'h0000, "R6 unmapped read");
        chk(ratio_o, 16'hBEEF, "R6 ratio untouched");
        chk(cfg_rw_o, 48'hA5A5_0000_1234, "R6 rw untouched");
        // R9 reserved slots
        hwrite(2'd2, 16'h7777);
        hwrite(2'd3, 16'h0001);
        hread(2'd0, 16'h0040, "R9 index unchanged");
        hread(2'd2, 16'h0000, "R9 slot2 zero");
        hread(2'd3, 16'h0000, "R9 slot3 zero");
        chk(cfg_rw_o, 48'hA5A5_0000_1234, "R9 rw untouched");
        // R8 minimum luma
        hwrite(2'd0, 16'h00AD);
        luma(1, 0, 8'h00);
        luma(0, 1, 8'h80);
        luma(0, 1, 8'h30);
        luma(0, 0, 8'h05);
        luma(0, 1, 8'h90);
        hread(2'd1, 16'h00FF, "R8 held until field start");
        luma(1, 0, 8'h00);
        hread(2'd1, 16'h0030, "R8 field minimum");
        // R7 read-only
        hwrite(2'd1, 16'h0001);
        hread(2'd1, 16'h0030, "R7 read-only write ignored");
        luma(0, 0, 8'h01);
        luma(1, 1, 8'h20);
        hread(2'd1, 16'h00FF, "R8 empty field");
        luma(0, 1, 8'h40);
        luma(1, 0, 8'h00);
        hread(2'd1, 16'h0020, "R8 sample with field start");
        // R10 idle cycles and back-to-back
        repeat (2) @(negedge clk);
        chk(host_rvalid, 0, "R10 idle");
        hread(2'd0, 16'h00AD, "R10 back-to-back a");
        hread(2'd1, 16'h0020, "R10 back-to-back b");
        repeat (3) @(negedge clk);
        chk(exp_q.size(), 0, "R10 all responses seen");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule